// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

The filter watches an Ethernet frame as it streams past, one byte per accepted beat. At the end of the frame it decides whether the frame may enter the receive buffer. Three checks are formed on the fly:

- a destination-address compare against a programmed 48-bit station address;
- a pattern checksum over bytes chosen by a 64-bit mask, compared with a programmed 16-bit value;
- the CRC verdict that an upstream checker supplies with the final byte.

A mode bit sets how the two selective checks combine. In AND mode, each enabled check must pass. In OR mode, any enabled check that passes admits the frame. A failed CRC, and an over-length frame when length checking is on, reject the frame whatever the other checks give.

The byte input is a valid/ready stream. `s_ready` is low while reset is asserted and high at every cycle after reset. The block therefore never applies back-pressure, and a byte moves on every cycle where `s_valid` is high once reset is released. Gaps with `s_valid` low may fall anywhere inside a frame. The first byte of the next frame may follow the final byte of the current frame in the very next cycle. The configuration inputs must be held stable from the first byte of a frame to its last byte.

Top module: `rx_accept_filter`

## Requirements
- R1: While reset is asserted, `dec_valid` and `s_ready` are low. In the first cycle after reset release, `s_ready` is high and `dec_valid` is low.
- R2: `dec_valid` is high for exactly the one cycle that follows each beat with `s_valid` and `s_last` both high. It is low in every other cycle, including cycles where `s_last` is high while `s_valid` is low.
- R3: When `cfg_crc_en` is 1 and `s_crc_ok` is 0 on the final beat, `dec_accept` is 0, whatever the other checks give.
- R4: The destination field is bytes 0 to 5, with byte 0 compared to `cfg_local_addr[47:40]` and byte 5 compared to `cfg_local_addr[7:0]`. In AND mode (`cfg_and_mode`=1) with `cfg_uni_en`=1, a frame whose destination field differs from the address in any of these bytes is rejected.
- R5: In OR mode (`cfg_and_mode`=0) with `cfg_uni_en`=1, a frame whose destination equals the local address is accepted, unless R3 or R7 vetoes it. A frame that matches no enabled check is rejected.
- R6: The pattern checksum works as follows.
  - Bit i of `cfg_pat_mask` selects frame byte i, for i from 0 to 63.
  - The selected bytes are taken in frame order. Each pair forms one 16-bit word, with the earlier byte as the high byte.
  - A final unpaired byte is padded with a zero low byte.
  - The words are summed with end-around carry, and the sum is inverted.
  - The pattern passes when the result equals `cfg_pat_sum`.
  - With `cfg_pat_en`=1, a failed pattern rejects the frame in AND mode, and a passed pattern accepts it in OR mode.
- R7: When `cfg_len_en` is 1 and the total byte count of the frame exceeds `cfg_max_len`, the frame is rejected. The count includes the CRC bytes. A frame whose count equals `cfg_max_len` is not rejected by this check.
- R8: With `cfg_uni_en`=0 and `cfg_pat_en`=0, every frame not vetoed by R3 or R7 is accepted, in either mode.
- R9: A frame shorter than 6 bytes never passes the destination check.
- R10: A frame that starts in the cycle right after the previous frame's final beat is judged from its own bytes only. This also holds when `s_valid` drops for some cycles inside a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Byte on `s_data` is valid |
| s_ready | output | 1 | Filter can take a byte (high after reset) |
| s_data | input | 8 | Frame byte, first byte of the frame first |
| s_last | input | 1 | Marks the final byte of the frame |
| s_crc_ok | input | 1 | CRC verdict, sampled with the final byte |
| cfg_and_mode | input | 1 | 1 = AND combining, 0 = OR combining |
| cfg_uni_en | input | 1 | Enables the destination-address check |
| cfg_crc_en | input | 1 | Enables the CRC veto |
| cfg_pat_en | input | 1 | Enables the pattern checksum check |
| cfg_len_en | input | 1 | Enables the maximum-length veto |
| cfg_local_addr | input | 48 | Station address, first wire byte in bits 47:40 |
| cfg_pat_mask | input | 64 | Byte-select mask for the pattern checksum |
| cfg_pat_sum | input | 16 | Expected inverted ones-complement sum |
| cfg_max_len | input | 16 | Maximum accepted frame length in bytes |
| dec_valid | output | 1 | Decision strobe, one cycle after the final beat |
| dec_accept | output | 1 | 1 = frame accepted (meaningful while `dec_valid` is high) |

## Verification
Two events can fall in the same cycle. One is the decision for a frame being registered and presented. The other is the first byte of the next frame arriving and restarting the address, checksum and byte-count state. The bench provokes this by chaining a frame that matches the station address directly behind one that does not, with no idle cycle between them. It judges each decision in its own strobe cycle. A second coincidence is also exercised: a selected final byte that is still unpaired when the frame ends, so that its pairing and its zero padding fall in the same cycle. A mask with an odd number of selected bytes provokes this, and the expected sums are worked out by hand.

// File: rtl/afilt_pkg.sv
package afilt_pkg;

  // Policy controls sampled with the last beat of a frame
  typedef struct packed {
    logic and_mode;
    logic uni_en;
    logic crc_en;
    logic pat_en;
    logic len_en;
  } filt_ctl_t;

  // 16-bit ones-complement addition with end-around carry
  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

endpackage

// File: rtl/afilt_addr_match.sv
module afilt_addr_match #(
  parameter int ADDR_BYTES = 6,
  parameter int IDX_W      = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      beat,
  input  logic                      first,
  input  logic [IDX_W-1:0]          idx,
  input  logic [7:0]                data,
  input  logic [8*ADDR_BYTES-1:0]   local_addr,
  output logic                      hit
);
  localparam int AW = 8 * ADDR_BYTES;
  localparam logic [IDX_W-1:0] HDR_LEN  = IDX_W'(ADDR_BYTES);
  localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(ADDR_BYTES - 1);

  logic       ok_q;
  logic       ok_cur;
  logic       in_hdr;
  logic [7:0] exp_b;

  // Byte of the station address expected at this position
  always_comb begin
    exp_b = 8'h00;
    for (int k = 0; k < ADDR_BYTES; k++) begin
      if (idx == IDX_W'(k)) exp_b = local_addr[AW-1-8*k -: 8];
    end
  end

  assign in_hdr = (idx < HDR_LEN);
  assign ok_cur = (first ? 1'b1 : ok_q) & (~in_hdr | (data == exp_b));
  assign hit    = ok_cur & (idx >= HDR_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    ok_q <= 1'b1;
    else if (beat) ok_q <= ok_cur;
  end

  // R4: once a header byte has mismatched, no later byte of the frame can hit
  a_r4_mismatch_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && in_hdr && (data != exp_b)) |=> (!beat || first || !hit));

endmodule

// File: rtl/afilt_pat_csum.sv
module afilt_pat_csum #(
  parameter int MASK_BYTES = 64,
  parameter int IDX_W      = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   beat,
  input  logic                   first,
  input  logic [IDX_W-1:0]       idx,
  input  logic [7:0]             data,
  input  logic [MASK_BYTES-1:0]  mask,
  input  logic [15:0]            want,
  output logic                   hit
);
  import afilt_pkg::*;

  localparam int MW = (MASK_BYTES > 1) ? $clog2(MASK_BYTES) : 1;
  localparam logic [IDX_W-1:0] MASK_END = IDX_W'(MASK_BYTES);

  logic [15:0] sum_q, sum_in, sum_nx, sum_fin;
  logic [7:0]  hi_q, hi_nx;
  logic        odd_q, odd_in, odd_nx;
  logic        sel;

  assign sel    = (idx < MASK_END) & mask[idx[MW-1:0]];
  assign sum_in = first ? 16'h0000 : sum_q;
  assign odd_in = first ? 1'b0 : odd_q;

  // Pair selected bytes high-then-low; an unpaired byte waits in hi_q
  always_comb begin
    sum_nx = sum_in;
    hi_nx  = hi_q;
    odd_nx = odd_in;
    if (sel) begin
      if (odd_in) begin
        sum_nx = oc_add(sum_in, {hi_q, data});
        odd_nx = 1'b0;
      end else begin
        hi_nx  = data;
        odd_nx = 1'b1;
      end
    end
  end

  // A trailing unpaired byte is padded with a zero low byte
  assign sum_fin = odd_nx ? oc_add(sum_nx, {hi_nx, 8'h00}) : sum_nx;
  assign hit     = (~sum_fin == want);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q <= 16'h0000;
      hi_q  <= 8'h00;
      odd_q <= 1'b0;
    end else if (beat) begin
      sum_q <= sum_nx;
      hi_q  <= hi_nx;
      odd_q <= odd_nx;
    end
  end

  // R6: the first byte of a frame leaves a pending half-word exactly when it is selected
  a_r6_first_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && first) |=> (odd_q == $past(sel)));

endmodule

// File: rtl/afilt_policy.sv
module afilt_policy (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fire,
  input  afilt_pkg::filt_ctl_t  ctl,
  input  logic                  uni_hit,
  input  logic                  pat_hit,
  input  logic                  crc_ok,
  input  logic                  too_long,
  output logic                  dec_valid,
  output logic                  dec_accept
);
  logic any_sel, and_ok, or_ok, base_ok, veto, acc;

  assign any_sel = ctl.uni_en | ctl.pat_en;
  assign and_ok  = (~ctl.uni_en | uni_hit) & (~ctl.pat_en | pat_hit);
  assign or_ok   = ~any_sel | (ctl.uni_en & uni_hit) | (ctl.pat_en & pat_hit);
  assign base_ok = ctl.and_mode ? and_ok : or_ok;
  assign veto    = (ctl.crc_en & ~crc_ok) | (ctl.len_en & too_long);
  assign acc     = base_ok & ~veto;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= fire;
      dec_accept <= fire & acc;
    end
  end

  a_r2_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> dec_valid);
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !dec_valid);
  a_r3_crc_veto: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctl.crc_en && !crc_ok) |=> !dec_accept);
  a_r7_len_veto: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctl.len_en && too_long) |=> !dec_accept);
  a_r4_and_uni: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctl.and_mode && ctl.uni_en && !uni_hit) |=> !dec_accept);
  a_r6_and_pat: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctl.and_mode && ctl.pat_en && !pat_hit) |=> !dec_accept);
  a_r5_or_uni: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ctl.and_mode && ctl.uni_en && uni_hit && !veto) |=> dec_accept);
  a_r8_open: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ctl.uni_en && !ctl.pat_en && !veto) |=> dec_accept);

endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int MASK_BYTES = 64,
  parameter int LEN_W      = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic [7:0]               s_data,
  input  logic                     s_last,
  input  logic                     s_crc_ok,
  input  logic                     cfg_and_mode,
  input  logic                     cfg_uni_en,
  input  logic                     cfg_crc_en,
  input  logic                     cfg_pat_en,
  input  logic                     cfg_len_en,
  input  logic [8*ADDR_BYTES-1:0]  cfg_local_addr,
  input  logic [MASK_BYTES-1:0]    cfg_pat_mask,
  input  logic [15:0]              cfg_pat_sum,
  input  logic [LEN_W-1:0]         cfg_max_len,
  output logic                     dec_valid,
  output logic                     dec_accept
);
  import afilt_pkg::*;

  localparam logic [LEN_W-1:0] IDX_MAX  = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] HDR_LAST = LEN_W'(ADDR_BYTES - 1);

  logic             rdy_q;
  logic             beat, fire, first;
  logic [LEN_W-1:0] idx_q;
  logic             too_long;
  logic             uni_hit, pat_hit;
  filt_ctl_t        ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign s_ready = rdy_q;
  assign beat    = s_valid & rdy_q;
  assign fire    = beat & s_last;
  assign first   = (idx_q == '0);

  // Position of the current byte within its frame, saturating
  always_ff @(posedge clk) begin
    if (!rst_n)              idx_q <= '0;
    else if (beat) begin
      if (s_last)            idx_q <= '0;
      else if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
    end
  end

  assign too_long = ({1'b0, idx_q} + {{LEN_W{1'b0}}, 1'b1}) > {1'b0, cfg_max_len};

  assign ctl = '{and_mode: cfg_and_mode, uni_en: cfg_uni_en, crc_en: cfg_crc_en,
                 pat_en: cfg_pat_en, len_en: cfg_len_en};

  afilt_addr_match #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(LEN_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .beat(beat), .first(first), .idx(idx_q),
    .data(s_data), .local_addr(cfg_local_addr), .hit(uni_hit));

  afilt_pat_csum #(.MASK_BYTES(MASK_BYTES), .IDX_W(LEN_W)) u_pat (
    .clk(clk), .rst_n(rst_n), .beat(beat), .first(first), .idx(idx_q),
    .data(s_data), .mask(cfg_pat_mask), .want(cfg_pat_sum), .hit(pat_hit));

  afilt_policy u_pol (
    .clk(clk), .rst_n(rst_n), .fire(fire), .ctl(ctl), .uni_hit(uni_hit),
    .pat_hit(pat_hit), .crc_ok(s_crc_ok), .too_long(too_long),
    .dec_valid(dec_valid), .dec_accept(dec_accept));

  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> s_ready);
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (idx_q == '0));
  a_r9_short_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (idx_q < HDR_LAST) && cfg_uni_en && (cfg_and_mode || !cfg_pat_en)) |=> !dec_accept);

endmodule

// File: tb/sim_rx_accept_filter.sv
module sim_rx_accept_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_last = 1'b0, s_crc_ok = 1'b0;
  logic [7:0]  s_data = 8'h00;
  logic        s_ready;
  logic        cfg_and_mode = 1'b0, cfg_uni_en = 1'b0, cfg_crc_en = 1'b0;
  logic        cfg_pat_en = 1'b0, cfg_len_en = 1'b0;
  logic [47:0] cfg_local_addr = 48'h02_00_00_12_34_56;
  logic [63:0] cfg_pat_mask = 64'h303F;
  logic [15:0] cfg_pat_sum = 16'hF7F9;
  logic [15:0] cfg_max_len = 16'd80;
  logic        dec_valid, dec_accept;

  int applied = 0;
  int miscomp = 0;
  logic [7:0] fb [0:127];

  always #10 clk = ~clk;

  rx_accept_filter u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .s_crc_ok(s_crc_ok), .cfg_and_mode(cfg_and_mode),
    .cfg_uni_en(cfg_uni_en), .cfg_crc_en(cfg_crc_en), .cfg_pat_en(cfg_pat_en),
    .cfg_len_en(cfg_len_en), .cfg_local_addr(cfg_local_addr),
    .cfg_pat_mask(cfg_pat_mask), .cfg_pat_sum(cfg_pat_sum),
    .cfg_max_len(cfg_max_len), .dec_valid(dec_valid), .dec_accept(dec_accept));

  typedef struct packed {
    logic [3:0] req;
    logic am, ue, ce, pe, le;
    logic [1:0] kind;
    logic [7:0] n;
    logic ok, expv, gap;
  } vec_t;

  // kind 0: broadcast ARP, 1: to station, 2: to other station, 3: broadcast IPv4
  localparam vec_t VECS [0:18] = '{
    '{4'd8, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd2, 8'd64, 1'b0, 1'b1, 1'b0}, // R8
    '{4'd8, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd2, 8'd64, 1'b0, 1'b1, 1'b1}, // R8
    '{4'd4, 1'b1,1'b1,1'b0,1'b0,1'b0, 2'd1, 8'd64, 1'b1, 1'b1, 1'b0}, // R4
    '{4'd4, 1'b1,1'b1,1'b0,1'b0,1'b0, 2'd2, 8'd64, 1'b1, 1'b0, 1'b1}, // R4
    '{4'd4, 1'b1,1'b1,1'b0,1'b0,1'b0, 2'd0, 8'd64, 1'b1, 1'b0, 1'b0}, // R4
    '{4'd5, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd1, 8'd64, 1'b1, 1'b1, 1'b1}, // R5
    '{4'd5, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd2, 8'd64, 1'b1, 1'b0, 1'b0}, // R5
    '{4'd6, 1'b0,1'b1,1'b0,1'b1,1'b0, 2'd0, 8'd64, 1'b1, 1'b1, 1'b0}, // R6
    '{4'd6, 1'b0,1'b1,1'b0,1'b1,1'b0, 2'd3, 8'd64, 1'b1, 1'b0, 1'b1}, // R6
    '{4'd4, 1'b1,1'b1,1'b0,1'b1,1'b0, 2'd0, 8'd64, 1'b1, 1'b0, 1'b0}, // R4
    '{4'd6, 1'b1,1'b0,1'b0,1'b1,1'b0, 2'd0, 8'd64, 1'b1, 1'b1, 1'b1}, // R6
    '{4'd6, 1'b1,1'b0,1'b0,1'b1,1'b0, 2'd3, 8'd64, 1'b1, 1'b0, 1'b0}, // R6
    '{4'd3, 1'b0,1'b1,1'b1,1'b1,1'b0, 2'd1, 8'd64, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd3, 1'b0,1'b1,1'b1,1'b1,1'b0, 2'd1, 8'd64, 1'b1, 1'b1, 1'b1}, // R3
    '{4'd3, 1'b0,1'b0,1'b1,1'b0,1'b0, 2'd2, 8'd64, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd7, 1'b1,1'b0,1'b0,1'b0,1'b1, 2'd2, 8'd80, 1'b0, 1'b1, 1'b1}, // R7
    '{4'd7, 1'b1,1'b0,1'b0,1'b0,1'b1, 2'd2, 8'd81, 1'b0, 1'b0, 1'b0}, // R7
    '{4'd7, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd2, 8'd81, 1'b0, 1'b1, 1'b1}, // R7
    '{4'd7, 1'b0,1'b1,1'b0,1'b1,1'b1, 2'd1, 8'd81, 1'b1, 1'b0, 1'b0}  // R7
  };

  task automatic check(input string req, input logic act, input logic expv);
    applied++;
    if (act !== expv) begin
      miscomp++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, expv, $time);
    end
  endtask

  task automatic build(input int kind);
    for (int i = 0; i < 128; i++) fb[i] = 8'((i * 7 + 3) & 8'hFF);
    for (int i = 6; i < 12; i++) fb[i] = 8'(8'h10 + i);
    for (int i = 0; i < 6; i++) begin
      case (kind)
        1: fb[i] = cfg_local_addr[47-8*i -: 8];
        2: fb[i] = (i == 5) ? 8'h57 : cfg_local_addr[47-8*i -: 8];
        default: fb[i] = 8'hFF;
      endcase
    end
    fb[12] = 8'h08;
    fb[13] = (kind == 0) ? 8'h06 : 8'h00;
  endtask

  // Called at a negedge; returns at the negedge after the final beat
  task automatic send(input int n, input logic ok, input logic gap, input logic chain,
                      output logic v, output logic a);
    for (int i = 0; i < n; i++) begin
      if (gap && i == 3) begin
        s_valid = 1'b0;
        @(negedge clk);
      end
      if (i == 2) check("R2 quiet mid-frame", dec_valid, 1'b0);
      s_valid  = 1'b1;
      s_data   = fb[i];
      s_last   = (i == n - 1);
      s_crc_ok = ok;
      @(negedge clk);
    end
    v = dec_valid;
    a = dec_accept;
    if (!chain) begin
      s_valid = 1'b0;
      s_last  = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscomp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
    $finish;
  end

  initial begin
    logic v, a, v2, a2;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 ready in reset", s_ready, 1'b0);
    check("R1 strobe in reset", dec_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", s_ready, 1'b1);
    check("R1 strobe after reset", dec_valid, 1'b0);

    // Vector table
    for (int k = 0; k < 19; k++) begin
      cfg_and_mode = VECS[k].am; cfg_uni_en = VECS[k].ue; cfg_crc_en = VECS[k].ce;
      cfg_pat_en = VECS[k].pe; cfg_len_en = VECS[k].le;
      build(int'(VECS[k].kind));
      send(int'(VECS[k].n), VECS[k].ok, VECS[k].gap, 1'b0, v, a);
      check($sformatf("R2 strobe vec %0d", k), v, 1'b1);
      check($sformatf("R%0d accept vec %0d", VECS[k].req, k), a, VECS[k].expv);
      @(negedge clk);
      check("R2 strobe single cycle", dec_valid, 1'b0);
    end

    // R2: s_last without s_valid gives no decision
    s_last = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 no strobe without valid", dec_valid, 1'b0);
    s_last = 1'b0;

    // R6: odd selection count, bytes 0..2 of a broadcast -> ~(FFFF + FF00) = 00FF
    cfg_and_mode = 1'b1; cfg_uni_en = 1'b0; cfg_crc_en = 1'b0; cfg_len_en = 1'b0;
    cfg_pat_en = 1'b1; cfg_pat_mask = 64'h7; cfg_pat_sum = 16'h00FF;
    build(0);
    send(64, 1'b1, 1'b0, 1'b0, v, a);
    check("R6 odd pad match", a, 1'b1);
    cfg_pat_sum = 16'hF7F9;
    send(64, 1'b1, 1'b0, 1'b0, v, a);
    check("R6 odd pad mismatch", a, 1'b0);

    // R6: mask bit 63 picks byte 63 (0xBC) -> ~BC00 = 43FF
    cfg_pat_mask = 64'h8000_0000_0000_0000; cfg_pat_sum = 16'h43FF;
    build(2);
    send(70, 1'b1, 1'b1, 1'b0, v, a);
    check("R6 top mask bit", a, 1'b1);
    cfg_pat_mask = 64'h303F; cfg_pat_sum = 16'hF7F9;

    // R9: 5-byte frame whose bytes match the address prefix
    cfg_pat_en = 1'b0; cfg_uni_en = 1'b1;
    build(1);
    send(5, 1'b1, 1'b0, 1'b0, v, a);
    check("R9 short AND", a, 1'b0);
    cfg_and_mode = 1'b0;
    send(5, 1'b1, 1'b0, 1'b0, v, a);
    check("R9 short OR", a, 1'b0);

    // R10: back-to-back frames, non-matching then matching, no idle cycle
    build(2);
    send(64, 1'b1, 1'b0, 1'b1, v, a);
    build(1);
    send(64, 1'b1, 1'b0, 1'b0, v2, a2);
    check("R10 first strobe", v, 1'b1);
    check("R10 first reject", a, 1'b0);
    check("R10 second strobe", v2, 1'b1);
    check("R10 second accept", a2, 1'b1);
    // and the reverse order
    send(64, 1'b1, 1'b0, 1'b1, v, a);
    build(2);
    send(64, 1'b1, 1'b0, 1'b0, v2, a2);
    check("R10 matching then other accept", a, 1'b1);
    check("R10 matching then other reject", a2, 1'b0);

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
    $finish;
  end

endmodule